// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Rights Check

This block caches up to 32 page translations for a processor pipeline. Each lookup carries a 20-bit virtual page number, a 12-bit page offset, an access kind and a privilege flag. The page number is compared against every stored entry at once. The outcome is registered and appears one clock after the request. The outcome is one of three:

- a hit, which returns the physical address (the physical page number followed by the unchanged offset);
- a protection fault;
- a miss, which raises a request to an external page-table walker.

The walker answers with a refill. The refill carries the page number, the physical page number and four permission bits: readable, writable, executable and user-accessible. The block writes the refill into the table. If a valid entry already holds that page number, the refill overwrites it. Otherwise the refill goes to the lowest-numbered invalid entry. If every entry is valid, the refill replaces the entry chosen by a first-in first-out pointer. A flush input drops every translation in one cycle.

A two-state controller governs lookups. In READY, lookups are accepted. A lookup that misses (and is not accompanied by a flush) moves the controller from READY to WALK. In WALK, the walker request is held high and new lookups are ignored. A refill or a flush moves the controller from WALK back to READY.

Top module: `tlb_xlate`

## Requirements
- R1: After reset there is no response, the walk request is low and every entry is invalid, so the first lookup of any page misses.
- R2: A lookup accepted at one clock edge is answered at that same edge: the response flags are visible in the following cycle. A permitted hit reports `rsp_hit_o` with `rsp_paddr_o` = {physical page, offset}, and exactly one of hit, miss or fault is set whenever `rsp_valid_o` is high.
- R3: A miss reports `rsp_miss_o` with a zero address and raises `walk_req_o`, with `walk_vpn_o` holding the missing page until a refill or flush arrives. Lookups presented during the walk get no response.
- R4: A refill stores the translation with its dirty bit clear and ends a pending walk. Later lookups of that page hit.
- R5: The access kind is coded as 0 = read, 1 = write, 2 = instruction fetch, and 3 always faults. A read needs the readable bit, a write the writable bit, and a fetch the executable bit. A hit that lacks the right reports `rsp_fault_o` with a zero address and no dirty flag.
- R6: With `req_user_i` = 1, an access also needs the user-accessible bit. With `req_user_i` = 0, that bit is not consulted.
- R7: A permitted write hit sets the entry's dirty bit. `rsp_dirty_o` on a hit shows the dirty bit after the access. A faulting write leaves the bit clear.
- R8: A refill of a new page uses the lowest-numbered invalid entry first. When all entries are valid, it evicts the entry at a wrap-around FIFO pointer. The pointer starts at entry 0 after reset and advances by one on each such eviction.
- R9: A refill whose page already matches a valid entry overwrites that entry in place, so no duplicate entry exists and no other entry is evicted.
- R10: A flush invalidates every entry by the next cycle, aborts a pending walk and takes precedence over a refill in the same cycle. A lookup presented in a flush cycle gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request |
| req_vpn_i | input | 20 | Virtual page number of the lookup |
| req_off_i | input | 12 | Page offset, passed through |
| req_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Permitted translation |
| rsp_miss_o | output | 1 | No matching entry |
| rsp_fault_o | output | 1 | Matching entry forbids the access |
| rsp_paddr_o | output | 32 | Physical address on a hit, else zero |
| rsp_dirty_o | output | 1 | Dirty bit of the hit entry after the access |
| walk_req_o | output | 1 | Page-table walk requested |
| walk_vpn_o | output | 20 | Page to be walked |
| fill_valid_i | input | 1 | Refill strobe |
| fill_vpn_i | input | 20 | Refill virtual page number |
| fill_ppn_i | input | 20 | Refill physical page number |
| fill_rd_i | input | 1 | Refill readable bit |
| fill_wr_i | input | 1 | Refill writable bit |
| fill_ex_i | input | 1 | Refill executable bit |
| fill_usr_i | input | 1 | Refill user-accessible bit |

## Verification
The assertions watch, on every cycle, that each response carries exactly one outcome and that misses and faults carry no address. They also check that a miss raises the walk request and that the request and its page stay fixed until a refill or flush. Further checks are that a refill in WALK drops the request, that a flush empties the valid bits, and that no page ever matches two entries. Only the bench scenarios can show the translations themselves: the permission matrix across access kinds and privilege, the dirty bit history, and the FIFO eviction order once the table is full, including in-place overwrite of an existing page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_WALK  = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
        logic usr;
    } perm_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vld_i,
    input  logic [VPN_W-1:0]   tag_i [ENTRIES],
    input  logic [VPN_W-1:0]   key_i,
    output logic [ENTRIES-1:0] hit_vec_o,
    output logic [IDX_W-1:0]   idx_o
);
    // compare the key against every entry in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec_o[g] = vld_i[g] && (tag_i[g] == key_i);
    end

    // one-hot to index; correct because duplicates are never created
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec_o[i]) idx_o = idx_o | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vld_i,
    input  logic               advance_i,
    output logic               has_free_o,
    output logic [IDX_W-1:0]   free_idx_o,
    output logic [IDX_W-1:0]   fifo_idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    // lowest-numbered invalid entry
    always_comb begin
        has_free_o = 1'b0;
        free_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                has_free_o = 1'b1;
                free_idx_o = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance_i) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign fifo_idx_o = ptr_q;
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
    import tlb_pkg::*;
(
    input  perm_t      perm_i,
    input  logic [1:0] kind_i,
    input  logic       user_i,
    output logic       allow_o
);
    logic kind_ok;

    always_comb begin
        unique case (acc_kind_e'(kind_i))
            ACC_READ:  kind_ok = perm_i.rd;
            ACC_WRITE: kind_ok = perm_i.wr;
            ACC_FETCH: kind_ok = perm_i.ex;
            default:   kind_ok = 1'b0;
        endcase
    end

    assign allow_o = kind_ok && (!user_i || perm_i.usr);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PA_W   = PPN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             req_valid_i,
    input  logic [VPN_W-1:0] req_vpn_i,
    input  logic [OFF_W-1:0] req_off_i,
    input  logic [1:0]       req_kind_i,
    input  logic             req_user_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic             rsp_miss_o,
    output logic             rsp_fault_o,
    output logic [PA_W-1:0]  rsp_paddr_o,
    output logic             rsp_dirty_o,
    output logic             walk_req_o,
    output logic [VPN_W-1:0] walk_vpn_o,
    input  logic             fill_valid_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PPN_W-1:0] fill_ppn_i,
    input  logic             fill_rd_i,
    input  logic             fill_wr_i,
    input  logic             fill_ex_i,
    input  logic             fill_usr_i
);
    // entry storage
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] dty_q;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    perm_t              perm_q [ENTRIES];

    walk_state_e state_q, state_d;

    // lookup path
    logic [ENTRIES-1:0] lk_hit_vec;
    logic [IDX_W-1:0]   lk_idx;
    logic               lk_hit, lk_allow, look_en, lk_ok, set_dirty;

    // refill path
    logic [ENTRIES-1:0] fill_hit_vec;
    logic [IDX_W-1:0]   fill_hit_idx, free_idx, fifo_idx, fill_idx;
    logic               fill_en, fill_hit, has_free, evict;

    // response registers
    logic             rsp_valid_q, rsp_hit_q, rsp_miss_q, rsp_fault_q, rsp_dirty_q;
    logic [PA_W-1:0]  rsp_paddr_q;
    logic [VPN_W-1:0] walk_vpn_q;

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
        .vld_i     (vld_q),
        .tag_i     (tag_q),
        .key_i     (req_vpn_i),
        .hit_vec_o (lk_hit_vec),
        .idx_o     (lk_idx)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_match (
        .vld_i     (vld_q),
        .tag_i     (tag_q),
        .key_i     (fill_vpn_i),
        .hit_vec_o (fill_hit_vec),
        .idx_o     (fill_hit_idx)
    );

    tlb_perm u_perm (
        .perm_i  (perm_q[lk_idx]),
        .kind_i  (req_kind_i),
        .user_i  (req_user_i),
        .allow_o (lk_allow)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (vld_q),
        .advance_i  (evict),
        .has_free_o (has_free),
        .free_idx_o (free_idx),
        .fifo_idx_o (fifo_idx)
    );

    assign lk_hit    = |lk_hit_vec;
    assign look_en   = req_valid_i && (state_q == ST_READY) && !flush_i;
    assign lk_ok     = look_en && lk_hit && lk_allow;
    assign set_dirty = lk_ok && (acc_kind_e'(req_kind_i) == ACC_WRITE);

    assign fill_hit = |fill_hit_vec;
    assign fill_en  = fill_valid_i && !flush_i;
    assign evict    = fill_en && !fill_hit && !has_free;
    assign fill_idx = fill_hit ? fill_hit_idx : (has_free ? free_idx : fifo_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: if (look_en && !lk_hit)        state_d = ST_WALK;
            ST_WALK:  if (flush_i || fill_valid_i)   state_d = ST_READY;
            default:                                 state_d = ST_READY;
        endcase
    end

    // response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_miss_q  <= 1'b0;
            rsp_fault_q <= 1'b0;
            rsp_dirty_q <= 1'b0;
            rsp_paddr_q <= '0;
            walk_vpn_q  <= '0;
        end else begin
            rsp_valid_q <= look_en;
            rsp_hit_q   <= lk_ok;
            rsp_miss_q  <= look_en && !lk_hit;
            rsp_fault_q <= look_en && lk_hit && !lk_allow;
            rsp_paddr_q <= lk_ok ? {ppn_q[lk_idx], req_off_i} : '0;
            rsp_dirty_q <= lk_ok && (dty_q[lk_idx] || set_dirty);
            if (look_en && !lk_hit) walk_vpn_q <= req_vpn_i;
        end
    end

    // valid and dirty bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            dty_q <= '0;
        end else begin
            if (set_dirty) dty_q[lk_idx] <= 1'b1;
            if (fill_en)   dty_q[fill_idx] <= 1'b0;
            if (flush_i)      vld_q <= '0;
            else if (fill_en) vld_q[fill_idx] <= 1'b1;
        end
    end

    // tag, page and permission payload
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx]  <= fill_vpn_i;
            ppn_q[fill_idx]  <= fill_ppn_i;
            perm_q[fill_idx] <= '{rd: fill_rd_i, wr: fill_wr_i, ex: fill_ex_i, usr: fill_usr_i};
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_hit_o   = rsp_hit_q;
    assign rsp_miss_o  = rsp_miss_q;
    assign rsp_fault_o = rsp_fault_q;
    assign rsp_paddr_o = rsp_paddr_q;
    assign rsp_dirty_o = rsp_dirty_q;
    assign walk_req_o  = (state_q == ST_WALK);
    assign walk_vpn_o  = walk_vpn_q;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 20,
    parameter int PA_W    = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               fill_valid_i,
    input logic               rsp_valid_o,
    input logic               rsp_hit_o,
    input logic               rsp_miss_o,
    input logic               rsp_fault_o,
    input logic [PA_W-1:0]    rsp_paddr_o,
    input logic               rsp_dirty_o,
    input logic               walk_req_o,
    input logic [VPN_W-1:0]   walk_vpn_o,
    input logic [ENTRIES-1:0] vld_q,
    input logic [ENTRIES-1:0] lk_hit_vec
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1); // R2

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> !(rsp_hit_o || rsp_miss_o || rsp_fault_o)); // R1

    AST_NO_ADDR_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss_o || rsp_fault_o) |-> (rsp_paddr_o == '0) && !rsp_dirty_o); // R5

    AST_MISS_WALKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss_o |-> walk_req_o); // R3

    AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_o && !fill_valid_i && !flush_i |=> walk_req_o && $stable(walk_vpn_o)); // R3

    AST_FILL_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_o && fill_valid_i |=> !walk_req_o); // R4

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld_q == '0) && !walk_req_o); // R10

    AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec)); // R9
endmodule

bind tlb_xlate tlb_xlate_chk #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .PA_W    (PA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .fill_valid_i (fill_valid_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_hit_o    (rsp_hit_o),
    .rsp_miss_o   (rsp_miss_o),
    .rsp_fault_o  (rsp_fault_o),
    .rsp_paddr_o  (rsp_paddr_o),
    .rsp_dirty_o  (rsp_dirty_o),
    .walk_req_o   (walk_req_o),
    .walk_vpn_o   (walk_vpn_o),
    .vld_q        (vld_q),
    .lk_hit_vec   (lk_hit_vec)
);

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;
    localparam int O_NONE = 0, O_HIT = 1, O_MISS = 2, O_FAULT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [19:0] req_vpn_i = '0;
    logic [11:0] req_off_i = '0;
    logic [1:0]  req_kind_i = '0;
    logic        req_user_i = 1'b0;
    logic        rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_fault_o, rsp_dirty_o;
    logic [31:0] rsp_paddr_o;
    logic        walk_req_o;
    logic [19:0] walk_vpn_o;
    logic        fill_valid_i = 1'b0;
    logic [19:0] fill_vpn_i = '0;
    logic [19:0] fill_ppn_i = '0;
    logic        fill_rd_i = 1'b0, fill_wr_i = 1'b0, fill_ex_i = 1'b0, fill_usr_i = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tlb_xlate dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .req_valid_i(req_valid_i), .req_vpn_i(req_vpn_i), .req_off_i(req_off_i),
        .req_kind_i(req_kind_i), .req_user_i(req_user_i),
        .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_miss_o(rsp_miss_o),
        .rsp_fault_o(rsp_fault_o), .rsp_paddr_o(rsp_paddr_o), .rsp_dirty_o(rsp_dirty_o),
        .walk_req_o(walk_req_o), .walk_vpn_o(walk_vpn_o),
        .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
        .fill_rd_i(fill_rd_i), .fill_wr_i(fill_wr_i), .fill_ex_i(fill_ex_i),
        .fill_usr_i(fill_usr_i)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int outcome();
        if (!rsp_valid_o) return O_NONE;
        if (rsp_hit_o)    return O_HIT;
        if (rsp_miss_o)   return O_MISS;
        if (rsp_fault_o)  return O_FAULT;
        return 9;
    endfunction

    // present one lookup, sample the registered response one cycle later
    task automatic look(input string req, input logic [19:0] vpn, input logic [11:0] off,
                        input logic [1:0] kind, input logic user, input int exp_o,
                        input logic [31:0] exp_pa, input logic exp_d);
        @(negedge clk);
        req_valid_i = 1'b1; req_vpn_i = vpn; req_off_i = off;
        req_kind_i = kind; req_user_i = user;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(req, "outcome", 64'(outcome()), 64'(exp_o));
        chk(req, "paddr", 64'(rsp_paddr_o), 64'(exp_pa));
        chk(req, "dirty", 64'(rsp_dirty_o), 64'(exp_d));
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic r, input logic w, input logic x, input logic u);
        @(negedge clk);
        fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn;
        fill_rd_i = r; fill_wr_i = w; fill_ex_i = x; fill_usr_i = u;
        @(negedge clk);
        fill_valid_i = 1'b0;
    endtask

    task automatic flush_pulse();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic t_reset_and_miss();
        chk("R1", "rsp_valid after reset", 64'(rsp_valid_o), 64'd0);
        chk("R1", "walk_req after reset", 64'(walk_req_o), 64'd0);
        look("R1", 20'h00100, 12'h123, 2'd0, 1'b1, O_MISS, 32'h0, 1'b0);
        chk("R3", "walk_req on miss", 64'(walk_req_o), 64'd1);
        chk("R3", "walk_vpn", 64'(walk_vpn_o), 64'h00100);
        look("R3", 20'h00200, 12'h0, 2'd0, 1'b1, O_NONE, 32'h0, 1'b0);
        chk("R3", "walk_req held", 64'(walk_req_o), 64'd1);
        fill(20'h00100, 20'h00ABC, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R4", "walk_req after refill", 64'(walk_req_o), 64'd0);
        look("R2", 20'h00100, 12'h123, 2'd0, 1'b1, O_HIT, 32'h00ABC123, 1'b0);
        look("R4", 20'h00100, 12'hFFF, 2'd0, 1'b0, O_HIT, 32'h00ABCFFF, 1'b0);
    endtask

    task automatic t_perm();
        fill(20'h00300, 20'h00333, 1'b1, 1'b0, 1'b0, 1'b1); // read-only user
        look("R5", 20'h00300, 12'h010, 2'd0, 1'b1, O_HIT, 32'h00333010, 1'b0);
        look("R5", 20'h00300, 12'h010, 2'd1, 1'b1, O_FAULT, 32'h0, 1'b0);
        look("R5", 20'h00300, 12'h010, 2'd2, 1'b1, O_FAULT, 32'h0, 1'b0);
        look("R5", 20'h00300, 12'h010, 2'd3, 1'b0, O_FAULT, 32'h0, 1'b0);
        fill(20'h00301, 20'h00444, 1'b0, 1'b0, 1'b1, 1'b1); // execute-only user
        look("R5", 20'h00301, 12'h004, 2'd2, 1'b1, O_HIT, 32'h00444004, 1'b0);
        look("R5", 20'h00301, 12'h004, 2'd0, 1'b1, O_FAULT, 32'h0, 1'b0);
        fill(20'h00302, 20'h00555, 1'b1, 1'b1, 1'b1, 1'b0); // kernel only
        look("R6", 20'h00302, 12'h008, 2'd0, 1'b1, O_FAULT, 32'h0, 1'b0);
        look("R6", 20'h00302, 12'h008, 2'd2, 1'b0, O_HIT, 32'h00555008, 1'b0);
    endtask

    task automatic t_dirty();
        look("R7", 20'h00100, 12'h020, 2'd1, 1'b1, O_HIT, 32'h00ABC020, 1'b1);
        look("R7", 20'h00100, 12'h024, 2'd0, 1'b1, O_HIT, 32'h00ABC024, 1'b1);
        look("R7", 20'h00300, 12'h000, 2'd0, 1'b1, O_HIT, 32'h00333000, 1'b0);
        fill(20'h00100, 20'h00ABD, 1'b1, 1'b1, 1'b0, 1'b1);
        look("R4", 20'h00100, 12'h000, 2'd0, 1'b1, O_HIT, 32'h00ABD000, 1'b0);
    endtask

    task automatic t_flush();
        flush_pulse();
        look("R10", 20'h00302, 12'h0, 2'd0, 1'b0, O_MISS, 32'h0, 1'b0);
        flush_pulse();
        chk("R10", "walk aborted", 64'(walk_req_o), 64'd0);
        @(negedge clk);
        flush_i = 1'b1; fill_valid_i = 1'b1; fill_vpn_i = 20'h00900; fill_ppn_i = 20'h00999;
        fill_rd_i = 1'b1; fill_usr_i = 1'b1;
        req_valid_i = 1'b1; req_vpn_i = 20'h00900;
        @(negedge clk);
        flush_i = 1'b0; fill_valid_i = 1'b0; req_valid_i = 1'b0;
        chk("R10", "no response in flush cycle", 64'(rsp_valid_o), 64'd0);
        look("R10", 20'h00900, 12'h0, 2'd0, 1'b1, O_MISS, 32'h0, 1'b0);
        flush_pulse();
    endtask

    task automatic t_fifo();
        for (int i = 0; i < 32; i++)
            fill(20'h01000 + 20'(i), 20'h02000 + 20'(i), 1'b1, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 32; i++)
            look("R8", 20'h01000 + 20'(i), 12'h5A5, 2'd0, 1'b1, O_HIT,
                 {20'h02000 + 20'(i), 12'h5A5}, 1'b0);
        fill(20'h01005, 20'h07777, 1'b1, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 32; i++)
            look("R9", 20'h01000 + 20'(i), 12'h001, 2'd0, 1'b1, O_HIT,
                 {(i == 5) ? 20'h07777 : 20'h02000 + 20'(i), 12'h001}, 1'b0);
        fill(20'h01100, 20'h03100, 1'b1, 1'b1, 1'b0, 1'b1); // evicts entry 0
        look("R8", 20'h01100, 12'h002, 2'd0, 1'b1, O_HIT, 32'h03100002, 1'b0);
        look("R8", 20'h01001, 12'h002, 2'd0, 1'b1, O_HIT, 32'h02001002, 1'b0);
        look("R8", 20'h01000, 12'h002, 2'd0, 1'b1, O_MISS, 32'h0, 1'b0);
        fill(20'h01101, 20'h03101, 1'b1, 1'b1, 1'b0, 1'b1); // evicts entry 1
        look("R8", 20'h01101, 12'h003, 2'd0, 1'b1, O_HIT, 32'h03101003, 1'b0);
        look("R8", 20'h01002, 12'h003, 2'd0, 1'b1, O_HIT, 32'h02002003, 1'b0);
        look("R8", 20'h01001, 12'h003, 2'd0, 1'b1, O_MISS, 32'h0, 1'b0);
        flush_pulse();
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_miss();
        t_perm();
        t_dirty();
        t_flush();
        t_fifo();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule